// File: doc/BRIEF.md
# Dual-Lane Serial Converter Receiver

This block takes the serial output of an external two-channel analog-to-digital converter and turns it into two parallel result words. The converter drives an active-low select line, a serial clock and two data lines; both lines carry one channel each and move in lockstep under the shared clock and select. The block runs entirely in the system clock domain: all four serial inputs first pass through a two-flop synchronizer, and the serial clock edges are found by comparing successive synchronized samples.

A falling select opens a frame and clears the bit counter. On each falling serial clock edge inside a frame, one bit per lane is shifted into that lane's register, most significant bit first, until `DATA_W` bits have arrived. The next rising serial clock edge copies both words to the outputs and raises a one-cycle valid pulse. A frame that ends early leaves the outputs alone, and bits past the word width are dropped.

Top module: `dual_adc_rx`

## Requirements
- R1: After reset, `word_a_o` and `word_b_o` are zero and `valid_o` is low.
- R2: Both lanes are captured in the same frame, most significant bit first, so `word_a_o` holds the `DATA_W` bits sent on `sdata_a_i` and `word_b_o` those sent on `sdata_b_i`.
- R3: Each data bit is taken at a falling edge of `sck_i`; data changing while `sck_i` is low does not alter the captured word.
- R4: The outputs change only at the rising `sck_i` edge that follows the `DATA_W`-th falling edge, not at that falling edge.
- R5: A frame in which `cs_ni` rises before `DATA_W` bits were captured leaves both outputs unchanged and raises no valid pulse.
- R6: A falling `cs_ni` restarts the bit count, so a full frame after a cut-short one is received correctly.
- R7: Bits after the `DATA_W`-th in one frame are ignored, and a frame updates the outputs at most once.
- R8: `valid_o` is high for exactly one system clock cycle per completed frame, in the cycle the new words appear.
- R9: Activity on `sck_i` and the data lines while `cs_ni` is high changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Converter select, active low, asynchronous |
| sck_i | input | 1 | Serial clock from the converter side, asynchronous |
| sdata_a_i | input | 1 | Serial data, lane A |
| sdata_b_i | input | 1 | Serial data, lane B |
| word_a_o | output | DATA_W | Last completed word, lane A |
| word_b_o | output | DATA_W | Last completed word, lane B |
| valid_o | output | 1 | One-cycle pulse when new words are present |

## Verification
The bench builds the receiver with `DATA_W` set to 4 instead of 11, which makes a sweep over every pair of lane-A and lane-B words (256 frames) affordable. Every frame inverts both data lines while the serial clock is low, so sampling on the wrong edge corrupts the words. Dedicated frames stop before the final rising edge, end early, run past the word width, and toggle the clock with select high.

// File: rtl/dual_adc_rx_pkg.sv
package dual_adc_rx_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t find_edge(input logic prev, input logic cur);
    edge_t e;
    e.rise = ~prev & cur;
    e.fall = prev & ~cur;
    return e;
  endfunction
endpackage

// File: rtl/dual_adc_rx_sync.sv
module dual_adc_rx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dual_adc_rx_capture.sv
module dual_adc_rx_capture
  import dual_adc_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sck_s_i,
  input  logic              da_s_i,
  input  logic              db_s_i,
  output logic [DATA_W-1:0] word_a_o,
  output logic [DATA_W-1:0] word_b_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic              cs_q, sck_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_a_q, sh_b_q;
  edge_t             sck_e, cs_e;

  assign sck_e = find_edge(sck_q, sck_s_i);
  assign cs_e  = find_edge(cs_q, cs_n_s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b1;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sh_a_q   <= '0;
      sh_b_q   <= '0;
      word_a_o <= '0;
      word_b_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      cs_q    <= cs_n_s_i;
      sck_q   <= sck_s_i;
      valid_o <= 1'b0;
      if (cs_e.fall) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
        sh_a_q <= '0;
        sh_b_q <= '0;
      end else if (!cs_n_s_i) begin
        if (sck_e.fall && cnt_q < CNT_FULL) begin
          sh_a_q <= {sh_a_q[DATA_W-2:0], da_s_i};
          sh_b_q <= {sh_b_q[DATA_W-2:0], db_s_i};
          cnt_q  <= cnt_q + 1'b1;
        end
        // transfer on the rise following the last captured bit
        if (sck_e.rise && cnt_q == CNT_FULL && !done_q) begin
          word_a_o <= sh_a_q;
          word_b_o <= sh_b_q;
          valid_o  <= 1'b1;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_hold_without_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(word_a_o) && $stable(word_b_o)));
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_valid_full_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cnt_q == CNT_FULL && done_q));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q && cs_n_s_i) |=> ($stable(cnt_q) && !valid_o));
endmodule

// File: rtl/dual_adc_rx.sv
module dual_adc_rx #(
  parameter int unsigned DATA_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdata_a_i,
  input  logic              sdata_b_i,
  output logic [DATA_W-1:0] word_a_o,
  output logic [DATA_W-1:0] word_b_o,
  output logic              valid_o
);
  // bit order: {cs_n, sck, lane_a, lane_b}
  logic [3:0] raw, synced;
  assign raw = {cs_ni, sck_i, sdata_a_i, sdata_b_i};

  dual_adc_rx_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  dual_adc_rx_capture #(
    .DATA_W(DATA_W)
  ) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_s_i(synced[3]),
    .sck_s_i (synced[2]),
    .da_s_i  (synced[1]),
    .db_s_i  (synced[0]),
    .word_a_o(word_a_o),
    .word_b_o(word_b_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/dual_adc_rx_tb_top.sv
module dual_adc_rx_tb_top;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, sda = 1'b0, sdb = 1'b0;
  logic [W-1:0] wa, wb;
  logic valid;
  int vcount = 0, multi = 0, checks = 0, fails = 0;
  logic valid_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_rx #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .sdata_a_i(sda), .sdata_b_i(sdb),
    .word_a_o(wa), .word_b_o(wb), .valid_o(valid)
  );

  always @(posedge clk) begin
    if (valid) vcount++;
    if (valid && valid_d) multi++;
    valid_d = valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send one frame; hold=1 checks R4 before the final rise
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input int nbits, input bit hold);
    logic [W-1:0] sa = a, sb = b;
    int v0;
    logic [W-1:0] oa, ob;
    oa = wa; ob = wb;
    cs_n = 1'b0;
    wait_n(H);
    for (int i = 0; i < nbits; i++) begin
      sda = sa[W-1]; sdb = sb[W-1];
      sa = sa << 1; sb = sb << 1;
      wait_n(H);
      sck = 1'b0;
      wait_n(2);
      sda = ~sda; sdb = ~sdb;  // R3: garbage while sck low
      wait_n(H-2);
      if (hold && i == nbits-1) begin
        v0 = vcount;
        wait_n(8);
        chk(vcount == v0, "R4 no update before rise", vcount, v0);
        chk(wa == oa, "R4 word_a held before rise", int'(wa), int'(oa));
        chk(wb == ob, "R4 word_b held before rise", int'(wb), int'(ob));
      end
      sck = 1'b1;
      wait_n(H);
    end
    wait_n(8);
    cs_n = 1'b1;
    wait_n(H);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int v0;
    logic [W-1:0] oa, ob;
    wait_n(3);
    chk(wa == 0 && wb == 0, "R1 words zero in reset", int'({wa, wb}), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(wa == 0 && wb == 0, "R1 words zero after reset", int'({wa, wb}), 0);
    chk(valid == 0 && vcount == 0, "R1 valid low", vcount, 0);

    // R2/R3/R8: exhaustive sweep of lane pairs
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        v0 = vcount;
        send(W'(a), W'(b), W, 1'b0);
        chk(int'(wa) == a, "R2 lane A word", int'(wa), a);
        chk(int'(wb) == b, "R2 lane B word", int'(wb), b);
        chk(vcount == v0 + 1, "R8 one valid per frame", vcount, v0 + 1);
      end
    end
    chk(multi == 0, "R8 valid single cycle", multi, 0);

    // R4: hold before final rising edge
    v0 = vcount;
    send(4'h5, 4'hA, W, 1'b1);
    chk(wa == 4'h5 && wb == 4'hA, "R4 update at rise", int'({wa, wb}), 8'h5A);
    chk(vcount == v0 + 1, "R4 valid after rise", vcount, v0 + 1);

    // R5: short frame
    oa = wa; ob = wb; v0 = vcount;
    send(4'h3, 4'hC, W - 2, 1'b0);
    chk(wa == oa && wb == ob, "R5 short frame keeps words", int'({wa, wb}), int'({oa, ob}));
    chk(vcount == v0, "R5 short frame no valid", vcount, v0);

    // R6: full frame after short one
    send(4'h9, 4'h6, W, 1'b0);
    chk(wa == 4'h9 && wb == 4'h6, "R6 restart after short frame", int'({wa, wb}), 8'h96);

    // R7: overlong frame, extra bits ignored
    v0 = vcount;
    send(4'hE, 4'h1, W + 3, 1'b0);
    chk(wa == 4'hE && wb == 4'h1, "R7 extra bits ignored", int'({wa, wb}), 8'hE1);
    chk(vcount == v0 + 1, "R7 single update", vcount, v0 + 1);

    // R9: clock and data toggle with select high
    oa = wa; ob = wb; v0 = vcount;
    for (int i = 0; i < 2 * W; i++) begin
      sda = i[0]; sdb = ~i[0];
      wait_n(H); sck = 1'b0; wait_n(H); sck = 1'b1;
    end
    wait_n(8);
    chk(wa == oa && wb == ob, "R9 idle select ignored", int'({wa, wb}), int'({oa, ob}));
    chk(vcount == v0, "R9 idle no valid", vcount, v0);
    chk(multi == 0, "R8 valid single cycle overall", multi, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule